// File: doc/BRIEF.md
# Three-Symbol Time-Code Pulse Classifier with Frame Alignment

This block turns a demodulated carrier envelope from a long-wave time signal into one symbol per second. Every second starts with a pulse whose length tells a zero, a one or a position marker apart. A debounced polarity input picks the broadcast convention. In one convention the measured pulse is the stretch of reduced carrier at the start of the second. In the other it is the stretch of full carrier that opens the second. Widths are counted in ticks of an external enable. With the default of 1000 ticks per second, one tick is one millisecond. The symbol thresholds are derived from that count.

Each classified second comes out with a one-cycle strobe. A frame tracker reads the stream of symbols. Two markers in a row mark the start of a minute, and from then on the tracker counts the second within the minute. It expects a marker at second 0 and at every second whose index ends in 9. A missing marker or a misplaced one releases alignment. Decoding of the time fields lies outside this block.

Top module: `tc_symbol_decoder`

## Requirements
- R1: The active level is carrier low when the debounced polarity is 0 and carrier high when it is 1. A symbol's width is the number of ticks that sample the active level, counted from the first such tick. The symbol is produced when a tick first samples the inactive level again.
- R2: With polarity 0, a width below 35 % of a second gives code 0 (zero). A width from 35 % up to but not including 65 % gives code 1 (one). A width from 65 % up to 95 % inclusive gives code 2 (marker).
- R3: With polarity 1, a width below 35 % of a second gives code 2 (marker). A width from 35 % up to but not including 65 % gives code 1 (one). A width from 65 % up to 95 % inclusive gives code 0 (zero).
- R4: A width below 10 % of a second, or above 95 %, gives code 3 (error) under either polarity.
- R5: `sym_valid` is high for exactly one clock cycle, in the cycle after the clock edge whose tick ends the pulse. `sym_code` is valid in that cycle.
- R6: The polarity input is sampled on ticks and filtered by a majority over the current and two previous samples. A value present on a single tick has no effect. A value held for two consecutive ticks takes effect at the second of them.
- R7: While unaligned, two consecutive marker symbols set `frame_locked`, with `sec_idx` equal to 0 at the second marker.
- R8: While aligned, each symbol advances `sec_idx` by one, and 59 wraps to 0. `frame_locked`, `sec_idx` and `lock_lost` change only one clock after a `sym_valid` cycle.
- R9: While aligned, alignment is dropped in two cases: a non-marker symbol lands at second 0 or at a second ending in 9, or a marker lands anywhere else. On a drop, `lock_lost` pulses for one cycle and `sec_idx` returns to 0. An error symbol in a non-marker second keeps alignment.
- R10: After reset, `sym_valid`, `frame_locked`, `lock_lost` and `sec_idx` are all 0.
- R11: While not aligned, `sec_idx` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sampling enable, TICKS_PER_SEC pulses per second |
| carrier_in | input | 1 | Demodulated carrier level, 1 = full carrier |
| pol_in | input | 1 | Convention select, raw level before debouncing |
| sym_valid | output | 1 | One-cycle strobe for a classified second |
| sym_code | output | 2 | 0 zero, 1 one, 2 marker, 3 error |
| frame_locked | output | 1 | Minute alignment held |
| sec_idx | output | 6 | Second within the minute, 0 while unaligned |
| lock_lost | output | 1 | One-cycle pulse when alignment is dropped |

## Verification
A symbol is due in the cycle after the clock edge whose tick first samples the inactive level. The bench times each pulse in whole ticks and checks the strobe at the next falling clock edge. It then checks at the falling edge after that, to confirm the strobe has cleared. The frame outputs lag the strobe by one more register. The bench's monitor therefore records the code on the strobe cycle, and records the lock, index and drop flag one falling edge later. Every frame check compares against that delayed record. The polarity filter adds two ticks before a new convention applies, so the bench waits out a switch before it sends symbols.

// File: rtl/tc_symbol_pkg.sv
package tc_symbol_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_MARK = 2'd2,
    SYM_ERR  = 2'd3
  } sym_e;

  localparam int unsigned SECS_PER_MIN = 60;

  // two-of-three vote
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // width -> symbol; inv selects the convention where the short pulse is the marker
  function automatic sym_e classify(input int unsigned w, input logic inv,
                                    input int unsigned t_min, input int unsigned t_lo,
                                    input int unsigned t_hi, input int unsigned t_max);
    if (w < t_min || w > t_max) return SYM_ERR;
    if (w < t_lo)               return inv ? SYM_MARK : SYM_ZERO;
    if (w < t_hi)               return SYM_ONE;
    return inv ? SYM_ZERO : SYM_MARK;
  endfunction

  function automatic logic [5:0] next_sec(input logic [5:0] s);
    return (s == 6'(SECS_PER_MIN - 1)) ? 6'd0 : s + 6'd1;
  endfunction

  // seconds that must carry a marker: 0 and every index ending in 9
  function automatic logic marker_slot(input logic [5:0] s);
    return (s == 6'd0) || ((s % 6'd10) == 6'd9);
  endfunction

endpackage

// File: rtl/tc_pol_filter.sv
module tc_pol_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pol_in,
  output logic pol_db
);
  import tc_symbol_pkg::*;

  logic [1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= 2'b00;
      pol_db <= 1'b0;
    end else if (tick) begin
      hist   <= {hist[0], pol_in};
      pol_db <= maj3(hist[1], hist[0], pol_in);
    end
  end

endmodule

// File: rtl/tc_pulse_timer.sv
module tc_pulse_timer #(
  parameter int unsigned TICKS_PER_SEC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       carrier_in,
  input  logic       pol_db,
  output logic       sym_valid,
  output logic [1:0] sym_code
);
  import tc_symbol_pkg::*;

  localparam int unsigned T_MIN = TICKS_PER_SEC / 10;
  localparam int unsigned T_LO  = (TICKS_PER_SEC * 35) / 100;
  localparam int unsigned T_HI  = (TICKS_PER_SEC * 65) / 100;
  localparam int unsigned T_MAX = (TICKS_PER_SEC * 95) / 100;
  localparam int unsigned SAT   = T_MAX + 1;
  localparam int unsigned CW    = $clog2(SAT + 1);

  logic          pulse_now;
  logic          pulse_q;
  logic          pulse_rise;
  logic          pulse_fall;
  logic [CW-1:0] cnt;
  sym_e          code_q;

  assign pulse_now  = pol_db ? carrier_in : ~carrier_in;
  assign pulse_rise = tick &  pulse_now & ~pulse_q;
  assign pulse_fall = tick & ~pulse_now &  pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      cnt     <= '0;
    end else if (tick) begin
      pulse_q <= pulse_now;
      if (pulse_rise)
        cnt <= CW'(1);
      else if (pulse_now && cnt != CW'(SAT))
        cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_valid <= 1'b0;
      code_q    <= SYM_ZERO;
    end else begin
      sym_valid <= pulse_fall;
      if (pulse_fall)
        code_q <= classify(32'(cnt), pol_db, T_MIN, T_LO, T_HI, T_MAX);
    end
  end

  assign sym_code = code_q;

endmodule

// File: rtl/tc_frame_track.sv
module tc_frame_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [1:0] sym_code,
  output logic       frame_locked,
  output logic [5:0] sec_idx,
  output logic       lock_lost
);
  import tc_symbol_pkg::*;

  logic       prev_mark;
  logic       is_mark;
  logic [5:0] nxt_sec;
  logic       slot_ok;

  assign is_mark = (sym_code == SYM_MARK);
  assign nxt_sec = next_sec(sec_idx);
  assign slot_ok = (is_mark == marker_slot(nxt_sec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_locked <= 1'b0;
      sec_idx      <= 6'd0;
      prev_mark    <= 1'b0;
      lock_lost    <= 1'b0;
    end else begin
      lock_lost <= 1'b0;
      if (sym_valid) begin
        prev_mark <= is_mark;
        if (!frame_locked) begin
          if (is_mark && prev_mark) begin
            frame_locked <= 1'b1;
            sec_idx      <= 6'd0;
          end
        end else if (slot_ok) begin
          sec_idx <= nxt_sec;
        end else begin
          frame_locked <= 1'b0;
          sec_idx      <= 6'd0;
          lock_lost    <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tc_symbol_decoder.sv
module tc_symbol_decoder #(
  parameter int unsigned TICKS_PER_SEC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       carrier_in,
  input  logic       pol_in,
  output logic       sym_valid,
  output logic [1:0] sym_code,
  output logic       frame_locked,
  output logic [5:0] sec_idx,
  output logic       lock_lost
);

  logic pol_db;

  tc_pol_filter u_pol (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .pol_in (pol_in),
    .pol_db (pol_db)
  );

  tc_pulse_timer #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .carrier_in (carrier_in),
    .pol_db     (pol_db),
    .sym_valid  (sym_valid),
    .sym_code   (sym_code)
  );

  tc_frame_track u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .sym_valid    (sym_valid),
    .sym_code     (sym_code),
    .frame_locked (frame_locked),
    .sec_idx      (sec_idx),
    .lock_lost    (lock_lost)
  );

endmodule

// File: rtl/tc_symbol_decoder_chk.sv
module tc_symbol_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       pol_db,
  input logic       sym_valid,
  input logic [1:0] sym_code,
  input logic       frame_locked,
  input logic [5:0] sec_idx,
  input logic       lock_lost
);

  AST_SYM_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> $past(tick)); // R5

  AST_SYM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid); // R5

  AST_POL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(pol_db)); // R6

  AST_LOCK_ON_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_locked) |-> ($past(sym_valid) && $past(sym_code) == 2'd2 && sec_idx == 6'd0)); // R7

  AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_locked && $past(frame_locked) && $past(sym_valid)) |->
      (sec_idx == (($past(sec_idx) == 6'd59) ? 6'd0 : $past(sec_idx) + 6'd1))); // R8

  AST_FRAME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sym_valid) |-> ($stable(sec_idx) && $stable(frame_locked) && !lock_lost)); // R8

  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_idx <= 6'd59); // R8

  AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |-> (!frame_locked && $past(frame_locked) && sec_idx == 6'd0)); // R9

  AST_UNLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_locked |-> (sec_idx == 6'd0)); // R11

endmodule

bind tc_symbol_decoder tc_symbol_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .pol_db       (pol_db),
  .sym_valid    (sym_valid),
  .sym_code     (sym_code),
  .frame_locked (frame_locked),
  .sec_idx      (sec_idx),
  .lock_lost    (lock_lost)
);

// File: tb/tc_symbol_decoder_bench.sv
`timescale 1ns/1ps
module tc_symbol_decoder_bench;

  localparam int TPS = 100;
  localparam int NVEC = 15;
  // {pol, width in ticks (7b), expected code (2b)}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 7'd20, 2'd0}, {1'b0, 7'd50, 2'd1}, {1'b0, 7'd80, 2'd2},
    {1'b0, 7'd34, 2'd0}, {1'b0, 7'd35, 2'd1}, {1'b0, 7'd64, 2'd1},
    {1'b0, 7'd65, 2'd2}, {1'b0, 7'd95, 2'd2}, {1'b0, 7'd96, 2'd3},
    {1'b0, 7'd9,  2'd3}, {1'b0, 7'd10, 2'd0},
    {1'b1, 7'd20, 2'd2}, {1'b1, 7'd50, 2'd1}, {1'b1, 7'd80, 2'd0},
    {1'b1, 7'd97, 2'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic carrier_in = 1'b1;
  logic pol_in = 1'b0;
  logic sym_valid, frame_locked, lock_lost;
  logic [1:0] sym_code;
  logic [5:0] sec_idx;

  int total = 0;
  int bad = 0;
  bit pol_b = 1'b0;
  bit done = 1'b0;

  int  nlog = 0;
  bit  pend = 0;
  logic [1:0] code_log [256];
  logic       lk_log   [256];
  logic [5:0] sec_log  [256];
  logic       lost_log [256];

  always #5 clk = ~clk;

  tc_symbol_decoder #(.TICKS_PER_SEC(TPS)) u_tc_symbol_decoder (
    .clk(clk), .rst_n(rst_n), .tick(tick), .carrier_in(carrier_in), .pol_in(pol_in),
    .sym_valid(sym_valid), .sym_code(sym_code), .frame_locked(frame_locked),
    .sec_idx(sec_idx), .lock_lost(lock_lost)
  );

  // tick every second clock, changed on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      tick = ~tick;
    end
  end

  // monitor: code on the strobe cycle, frame state one cycle later
  always @(negedge clk) begin
    if (pend && nlog > 0) begin
      lk_log[nlog-1]   = frame_locked;
      sec_log[nlog-1]  = sec_idx;
      lost_log[nlog-1] = lock_lost;
      pend = 0;
    end
    if (rst_n && sym_valid && nlog < 256) begin
      code_log[nlog] = sym_code;
      nlog = nlog + 1;
      pend = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
    end
  endtask

  // v = active level; mapped to carrier by the bench's own convention
  task automatic drive_level(input bit v, input int n);
    @(negedge clk);
    carrier_in = pol_b ? v : ~v;
    wait_ticks(n);
  endtask

  task automatic send_sym(input int w);
    drive_level(1'b1, w);
    drive_level(1'b0, TPS - w);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pol_in = 1'b0; pol_b = 1'b0; carrier_in = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    nlog = 0; pend = 0;
  endtask

  task automatic switch_pol(input bit p);
    @(negedge clk);
    pol_in = p; pol_b = p;
    carrier_in = p ? 1'b0 : 1'b1;
    wait_ticks(3 * TPS);
  endtask

  initial begin
    int n0;
    do_reset();
    @(negedge clk);
    // R10 reset state
    chk(sym_valid == 0 && frame_locked == 0 && lock_lost == 0 && sec_idx == 0,
        "R10 reset outputs", {sym_valid, frame_locked, lock_lost, sec_idx}, 0);
    wait_ticks(10);

    // table walk: R1 R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      bit p; int w; int e;
      p = VEC[i][9]; w = int'(VEC[i][8:2]); e = int'(VEC[i][1:0]);
      if (p != pol_b) switch_pol(p);
      n0 = nlog;
      send_sym(w);
      chk(nlog == n0 + 1, "R1 one symbol per pulse", nlog - n0, 1);
      if (nlog == n0 + 1)
        chk(int'(code_log[n0]) == e, (e == 3) ? "R4 error width" : (p ? "R3 pol1 class" : "R2 pol0 class"),
            int'(code_log[n0]), e);
    end

    // R5 strobe timing, polarity 1
    drive_level(1'b1, 50);
    @(negedge clk);
    carrier_in = 1'b0;
    do @(posedge clk); while (!tick);
    @(negedge clk);
    chk(sym_valid == 1 && sym_code == 2'd1, "R5 strobe after end tick", {sym_valid, sym_code}, 5);
    @(negedge clk);
    chk(sym_valid == 0, "R5 strobe one cycle", sym_valid, 0);
    wait_ticks(40);

    // R6 single-tick glitch on polarity ignored (pol_b stays 1)
    n0 = nlog;
    @(negedge clk);
    while (!tick) @(negedge clk);
    pol_in = 1'b0;
    @(negedge clk); @(negedge clk);
    pol_in = 1'b1;
    wait_ticks(20);
    chk(nlog == n0, "R6 glitch ignored", nlog - n0, 0);
    send_sym(20);
    chk(nlog == n0 + 1 && code_log[n0] == 2'd2, "R6 polarity kept", int'(code_log[n0]), 2);

    // frame tests, polarity 0
    do_reset();
    wait_ticks(5);
    send_sym(20);
    chk(lk_log[0] == 0 && sec_log[0] == 0, "R11 unaligned index", int'(sec_log[0]), 0);
    send_sym(80);
    chk(lk_log[1] == 0, "R7 one marker no lock", lk_log[1], 0);
    send_sym(80);
    chk(lk_log[2] == 1 && sec_log[2] == 0, "R7 lock at two markers", {lk_log[2], sec_log[2]}, 64);
    for (int s = 1; s <= 60; s++) begin
      int es;
      es = s % 60;
      n0 = nlog;
      if (s == 1) send_sym(5);
      else if (es == 0 || es % 10 == 9) send_sym(80);
      else send_sym(20);
      if (s == 1)
        chk(lk_log[n0] == 1 && sec_log[n0] == 1, "R9 error keeps lock", {lk_log[n0], sec_log[n0]}, 65);
      else
        chk(lk_log[n0] == 1 && int'(sec_log[n0]) == es, "R8 index advance", int'(sec_log[n0]), es);
    end
    // missing marker at second 9
    for (int s = 1; s <= 8; s++) send_sym(20);
    n0 = nlog;
    send_sym(20);
    chk(lk_log[n0] == 0 && lost_log[n0] == 1 && sec_log[n0] == 0, "R9 missing marker drop",
        {lk_log[n0], lost_log[n0], sec_log[n0]}, 64);
    chk(lost_log[n0 - 1] == 0, "R9 no drop before", lost_log[n0 - 1], 0);
    // relock, then a stray marker at second 3
    send_sym(80); send_sym(80);
    chk(lk_log[nlog-1] == 1, "R7 relock", lk_log[nlog-1], 1);
    send_sym(20); send_sym(20);
    n0 = nlog;
    send_sym(80);
    chk(lk_log[n0] == 0 && lost_log[n0] == 1, "R9 stray marker drop", {lk_log[n0], lost_log[n0]}, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule